// File: doc/BRIEF.md
# Byte-Wide Host Configuration Loader

This block lets a host processor push configuration data into a device one byte at a time, treating the loader as a simple write-only peripheral. A host write is recognized only when the write strobe and three chip selects are all at their active levels together. Two selects are active low and one is active high. The strobe and the selects are synchronized into the system clock domain. The byte that was present while the write was qualified is captured once, when the qualified condition ends.

The captured byte sits in a buffer register. From there it is shifted out most significant bit first on a serial data output. Each bit is framed by one period of a configuration clock that the block derives from the system clock. A downstream shift chain or a string of slave devices can sample the serial output on the rising edge of that clock. In this way the loader leads a daisy chain. A ready output tells the host when the next byte may be written. A write that arrives while a byte is still being shifted is dropped, and a one-cycle error pulse reports it.

The control state machine has three states. IDLE: ready high, clock low, output high. BIT_LOW: configuration clock low, current bit driven. BIT_HIGH: configuration clock high, current bit held. The transitions are:
- **ACCEPT**: IDLE to BIT_LOW on a capture while idle.
- **RISE**: BIT_LOW to BIT_HIGH when the half-period timer expires.
- **NEXT**: BIT_HIGH to BIT_LOW when the timer expires and bits remain.
- **FINISH**: BIT_HIGH to IDLE when the timer expires after the last bit.
- **RESET**: any state to IDLE on synchronous reset.

Top module: `cfg_byte_loader`

## Requirements
- R1: A capture happens only when wr_n=0, cs0_n=0, cs1_n=0 and cs2=1 are all present at once. With any one of them inactive, a strobe pulse produces no configuration clock edge and ready stays high.
- R2: One qualified write yields exactly one captured byte, however many cycles the strobe is held low. The byte captured is the din value seen during the last qualified cycle.
- R3: A byte is sent most significant bit first as exactly 8 rising edges of cclk. Dout is stable across each rising edge of cclk.
- R4: Successive cclk rising edges within one byte are 2*HALF_PERIOD system clock cycles apart.
- R5: Ready is low from acceptance until the last bit's clock-high phase ends, then returns high. A freshly accepted byte starts with cclk low.
- R6: A write that completes while ready is low is ignored. Wr_err is high for exactly one cycle, and the byte being shifted continues unchanged.
- R7: While ready is high, dout is 1 and cclk is 0.
- R8: A synchronous reset aborts any transfer and gives rdy=1, cclk=0, dout=1, wr_err=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Host write strobe, active low |
| cs0_n | input | 1 | Chip select, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| din | input | DATA_W (8) | Host data byte |
| dout | output | 1 | Serial configuration data, MSB first |
| cclk | output | 1 | Generated configuration clock |
| rdy | output | 1 | High when a new byte may be written |
| wr_err | output | 1 | One-cycle pulse for a write rejected while busy |

## Verification
The two functions that can fall in the same cycle are rejection of a host write and the ongoing serialization. The bench provokes this by issuing a second write a few cycles into a byte's transfer, so that the error pulse is raised in the middle of a shift. It judges the outcome in two ways. The scoreboard must see only the first byte, bit for bit and in order, with the clock period intact. The monitor must count exactly one wr_err cycle for that write. A long held strobe is also judged through the error count: a spurious second capture would land in the busy window and raise an error that the bench does not expect.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_BIT_LOW  = 2'd1,
        ST_BIT_HIGH = 2'd2
    } cbl_state_t;

endpackage

// File: rtl/cbl_wr_sync.sv
// Qualifies and synchronizes the host write, then emits one capture pulse
// when the qualified condition ends.
module cbl_wr_sync #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic [DATA_W-1:0] din,
    output logic              cap_pulse,
    output logic [DATA_W-1:0] cap_data
);

    logic                   qual_raw;
    logic [SYNC_STAGES-1:0] q_pipe;
    logic [DATA_W-1:0]      d_pipe [SYNC_STAGES];
    logic                   qual_prev;
    logic [DATA_W-1:0]      hold_q;

    assign qual_raw = ~wr_n & ~cs0_n & ~cs1_n & cs2;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_pipe <= '0;
        end else begin
            q_pipe <= {q_pipe[SYNC_STAGES-2:0], qual_raw};
        end
    end

    // data travels alongside its qualifier
    always_ff @(posedge clk) begin
        d_pipe[0] <= din;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            d_pipe[i] <= d_pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qual_prev <= 1'b0;
            hold_q    <= '0;
        end else begin
            qual_prev <= q_pipe[SYNC_STAGES-1];
            if (q_pipe[SYNC_STAGES-1]) begin
                hold_q <= d_pipe[SYNC_STAGES-1];
            end
        end
    end

    assign cap_pulse = qual_prev & ~q_pipe[SYNC_STAGES-1];
    assign cap_data  = hold_q;

endmodule

// File: rtl/cbl_half_timer.sv
// Counts system clocks while running and flags each elapsed half period.
module cbl_half_timer #(
    parameter int HALF_PERIOD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == CNT_W'(HALF_PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
    import cbl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_PERIOD = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic [DATA_W-1:0] din,
    output logic              dout,
    output logic              cclk,
    output logic              rdy,
    output logic              wr_err
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    cbl_state_t        state_q, state_d;
    logic              cap_pulse;
    logic [DATA_W-1:0] cap_data;
    logic              tick;
    logic              run;
    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              err_q;

    cbl_wr_sync #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_wr_sync (
        .clk       (clk),
        .rst       (rst),
        .wr_n      (wr_n),
        .cs0_n     (cs0_n),
        .cs1_n     (cs1_n),
        .cs2       (cs2),
        .din       (din),
        .cap_pulse (cap_pulse),
        .cap_data  (cap_data)
    );

    assign run = (state_q != ST_IDLE);

    cbl_half_timer #(
        .HALF_PERIOD (HALF_PERIOD)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cap_pulse) state_d = ST_BIT_LOW;
            ST_BIT_LOW:  if (tick)      state_d = ST_BIT_HIGH;
            ST_BIT_HIGH: if (tick)      state_d = (idx_q == LAST_IDX) ? ST_IDLE : ST_BIT_LOW;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath: buffer/shift register, bit index, rejection flag
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= cap_pulse && (state_q != ST_IDLE);
            if (state_q == ST_IDLE && cap_pulse) begin
                shreg_q <= cap_data;
                idx_q   <= '0;
            end else if (state_q == ST_BIT_HIGH && tick) begin
                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rdy    = 1'b1;
        cclk   = 1'b0;
        dout   = 1'b1;
        wr_err = err_q;
        unique case (state_q)
            ST_IDLE: begin
                rdy = 1'b1;
            end
            ST_BIT_LOW: begin
                rdy  = 1'b0;
                dout = shreg_q[DATA_W-1];
            end
            ST_BIT_HIGH: begin
                rdy  = 1'b0;
                cclk = 1'b1;
                dout = shreg_q[DATA_W-1];
            end
            default: begin
                rdy = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cbl_checker.sv
module cbl_checker (
    input logic clk,
    input logic rst,
    input logic rdy,
    input logic cclk,
    input logic dout,
    input logic wr_err
);

    // R7
    idle_dout_high_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |-> (dout && !cclk));

    // R3
    dout_stable_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cclk) |-> $stable(dout));

    // R6
    err_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> !$past(rdy));

    // R6
    err_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> !wr_err);

    // R5
    start_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy) |-> !cclk);

    // R8
    reset_outputs_chk: assert property (@(posedge clk)
        $past(rst) |-> (rdy && !cclk && dout && !wr_err));

endmodule

bind cfg_byte_loader cbl_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .rdy    (rdy),
    .cclk   (cclk),
    .dout   (dout),
    .wr_err (wr_err)
);

// File: tb/test_cfg_byte_loader.sv
module test_cfg_byte_loader;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1, cs0_n = 1'b1, cs1_n = 1'b1, cs2 = 1'b0;
    logic [7:0] din = 8'h00;
    logic       dout, cclk, rdy, wr_err;

    int checks = 0, failures = 0;
    int errs_seen = 0, errs_exp = 0, rises = 0;
    int cyc = 0, last_rise = 0, bits = 0;
    logic [7:0] shv = 8'h00;
    logic       cclk_prev = 1'b0;
    logic [7:0] exp_q[$];
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    cfg_byte_loader #(.DATA_W(8), .HALF_PERIOD(HALF), .SYNC_STAGES(2)) i_cfg_byte_loader (
        .clk(clk), .rst(rst), .wr_n(wr_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .cs2(cs2),
        .din(din), .dout(dout), .cclk(cclk), .rdy(rdy), .wr_err(wr_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: performs a host write and pushes the expected byte
    task automatic host_write(input logic [7:0] b, input int hold, input bit accept,
                              input bit c0n, input bit c1n, input bit c2);
        @(negedge clk);
        din = b; cs0_n = c0n; cs1_n = c1n; cs2 = c2; wr_n = 1'b0;
        if (accept) exp_q.push_back(b);
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        din = ~b; cs0_n = 1'b1; cs1_n = 1'b1; cs2 = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (!rdy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            bits = 0;
            cclk_prev = 1'b0;
        end else begin
            if (rdy) chk(dout === 1'b1 && cclk === 1'b0, "R7 idle levels", {dout, cclk}, 2'b10);
            if (wr_err) errs_seen++;
            if (cclk && !cclk_prev) begin
                rises++;
                chk(rdy === 1'b0, "R5 rdy low while shifting", rdy, 0);
                if (bits != 0)
                    chk(cyc - last_rise == 2 * HALF, "R4 cclk period", cyc - last_rise, 2 * HALF);
                last_rise = cyc;
                shv = {shv[6:0], dout};
                bits++;
                if (bits == 8) begin
                    bits = 0;
                    if (exp_q.size() == 0) begin
                        chk(0, "R3/R6 unexpected byte", shv, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(shv === e, "R3 serial byte MSB first", shv, e);
                    end
                end
            end
            cclk_prev = cclk;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rdy === 1 && cclk === 0 && dout === 1 && wr_err === 0, "R8 reset state",
            {rdy, cclk, dout, wr_err}, 4'b1010);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // basic patterns
        host_write(8'hA5, 1, 1, 0, 0, 1); wait_idle();
        chk(rdy === 1, "R5 rdy high after byte", rdy, 1);
        host_write(8'h80, 2, 1, 0, 0, 1); wait_idle();
        host_write(8'h01, 1, 1, 0, 0, 1); wait_idle();
        host_write(8'h3C, 3, 1, 0, 0, 1); wait_idle();

        // R1: one qualifier missing each time
        begin
            int r0;
            r0 = rises;
            host_write(8'hFF, 2, 0, 0, 0, 0);
            host_write(8'hFF, 2, 0, 1, 0, 1);
            host_write(8'hFF, 2, 0, 0, 1, 1);
            repeat (10) @(negedge clk);
            chk(rises == r0, "R1 no clock without full select", rises, r0);
            chk(rdy === 1, "R1 rdy stays high", rdy, 1);
        end

        // R2: long strobe -> single capture
        host_write(8'hC3, 12, 1, 0, 0, 1); wait_idle();
        chk(errs_seen == errs_exp, "R2 no second capture", errs_seen, errs_exp);

        // R6: write while busy overlaps ongoing shift
        host_write(8'h96, 1, 1, 0, 0, 1);
        while (rdy) @(negedge clk);
        host_write(8'h0F, 1, 0, 0, 0, 1);
        errs_exp++;
        wait_idle();
        chk(errs_seen == errs_exp, "R6 one error pulse", errs_seen, errs_exp);
        chk(exp_q.size() == 0, "R6 rejected byte not sent", exp_q.size(), 0);

        // R8: reset mid-transfer
        host_write(8'h5A, 1, 0, 0, 0, 1);
        while (rdy) @(negedge clk);
        repeat (9) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(rdy === 1 && cclk === 0 && dout === 1 && wr_err === 0, "R8 reset aborts",
            {rdy, cclk, dout, wr_err}, 4'b1010);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        host_write(8'h69, 1, 1, 0, 0, 1); wait_idle();

        chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
        chk(errs_seen == errs_exp, "R6 final error count", errs_seen, errs_exp);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule